// File: doc/BRIEF.md
# Configuration Data Streamer

This block reads configuration bytes from an internal store and sends them toward an FPGA configuration port. Bytes go out one per clock on an 8-bit bus, or one bit per clock on bit 0 of the bus. An internal address counter walks the store from address 0 up to a parameterised last address. The data comes with a gated copy of the input clock, so the receiver samples each value on a rising edge of that clock.

An active-low chip enable and an active-low output-enable/reset control the block. A stall input freezes the stream while the clock keeps running. When the stream ends, a cascade output goes low so that the next device in a chain can take over. The three-state pins are modelled as a value plus an enable: a low enable stands for high impedance.

The store is a synchronous memory model. It holds a computed pattern and always prefetches the byte that the counter will point to next.

Top module: `cfg_streamer`

## Requirements
- R1: After reset, with `ce_ni` high, `dout_en_o` and `clkout_en_o` are 0 and `ceo_o` is 1.
- R2: While `ce_ni` is high, `dout_en_o` is 0 and `ceo_o` is 1, whatever the level of `oe_rst_ni`. Both take effect at once, without waiting for a clock edge.
- R3: The byte at address a is (a*29 + 75) mod 256. When `ce_ni` is low and `oe_rst_ni` is high, `dout_en_o` rises at once and byte 0 is presented. The first clock edge that sees this starts CLKOUT and does not advance the counter. In parallel mode (`par_mode_i`=1), each later edge advances one address, so the byte at address a is on `dout_o` right after the edge numbered a+1.
- R4: In serial mode (`par_mode_i`=0), `dout_o[0]` carries each byte most significant bit first, one bit per clock. `dout_o[7:1]` is 0. The address advances after the eighth bit.
- R5: While `busy_i` is high, the address and bit position hold, `dout_o` keeps its value, and CLKOUT keeps toggling.
- R6: The clock edge that consumes the last bit or byte at `LAST_ADDR` ends the stream. While `ce_ni` stays low, `dout_en_o` and `clkout_en_o` are then 0 and `ceo_o` is 0.
- R7: If `ce_ni` rises while `oe_rst_ni` is high and before the stream has ended, `clkout_en_o` stays 1 for exactly `TAIL_CYC` (8) clock periods after the first edge that samples `ce_ni` high, then goes to 0.
- R8: When `oe_rst_ni` goes low, `clkout_en_o` drops to 0 at once, even during the tail, and the counter is reset.
- R9: Whenever the block is disabled (`ce_ni` high or `oe_rst_ni` low), the counter is cleared to address 0. The next enable restarts the stream at byte 0 with `ceo_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock input |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| oe_rst_ni | input | 1 | Output enable / counter reset, active low |
| busy_i | input | 1 | Stall request from the receiver |
| par_mode_i | input | 1 | 1 = 8-bit parallel, 0 = serial on bit 0 |
| dout_o | output | 8 | Configuration data |
| dout_en_o | output | 1 | Data pins driven (0 = high impedance) |
| clkout_o | output | 1 | Gated source-synchronous clock |
| clkout_en_o | output | 1 | CLKOUT driven (0 = high impedance) |
| ceo_o | output | 1 | Cascade enable to next device, active low |

## Verification
The assertions check on every cycle that:
- the prefetched byte always matches the counter's address;
- a stall freezes the address and bit position;
- a disable clears the counter;
- the end flag is only ever set at the last address;
- a low output-enable kills both the run flag and the tail;
- the tail counter never passes its bound and only starts from a running stream.

Only the bench scenarios can show the externally visible sequences:
- the exact edge on which each byte or serial bit appears;
- the length of the CLKOUT tail after chip enable rises;
- the immediate, edge-independent disable of CLKOUT and of the data pins;
- the restart at byte 0 after a disable.

// File: rtl/cfg_streamer_pkg.sv
package cfg_streamer_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BIT_W  = $clog2(BYTE_W);

  // stored image pattern: byte(a) = a*29 + 75 (mod 256)
  function automatic logic [BYTE_W-1:0] cfg_byte(input logic [31:0] a);
    logic [31:0] v;
    v = (a * 32'd29) + 32'd75;
    return v[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/cfg_mem.sv
module cfg_mem
  import cfg_streamer_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= cfg_byte(32'd0);
    else         rd_data_o <= cfg_byte(32'(rd_addr_i));
  end
endmodule

// File: rtl/cfg_addr_ctr.sv
module cfg_addr_ctr
  import cfg_streamer_pkg::*;
#(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned LAST_ADDR = 1048575
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic              par_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] addr_nxt_o,
  output logic [BIT_W-1:0]  bit_o,
  output logic              done_o,
  output logic              done_nxt_o
);
  localparam logic [ADDR_W-1:0] LastA   = ADDR_W'(LAST_ADDR);
  localparam logic [BIT_W-1:0]  LastBit = BIT_W'(BYTE_W - 1);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic              done_q, done_d;

  always_comb begin
    addr_d = addr_q;
    bit_d  = bit_q;
    done_d = done_q;
    if (clr_i) begin
      addr_d = '0;
      bit_d  = '0;
      done_d = 1'b0;
    end else if (step_i && !done_q) begin
      if (par_i || bit_q == LastBit) begin
        bit_d = '0;
        if (addr_q == LastA) done_d = 1'b1;
        else                 addr_d = addr_q + 1'b1;
      end else begin
        bit_d = bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      bit_q  <= bit_d;
      done_q <= done_d;
    end
  end

  assign addr_o     = addr_q;
  assign addr_nxt_o = addr_d;
  assign bit_o      = bit_q;
  assign done_o     = done_q;
  assign done_nxt_o = done_d;

  AST_DONE_AT_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> addr_q == LastA); // R6
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (addr_q == '0 && bit_q == '0 && !done_q)); // R9
endmodule

// File: rtl/cfg_clk_ctl.sv
module cfg_clk_ctl #(
  parameter int unsigned TAIL_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic oe_i,
  input  logic done_nxt_i,
  output logic run_o,
  output logic clk_en_o
);
  localparam int unsigned TW = $clog2(TAIL_CYC + 1);
  localparam logic [TW-1:0] TailLd = TW'(TAIL_CYC);

  logic          run_q;
  logic [TW-1:0] tail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      tail_q <= '0;
    end else begin
      run_q <= active_i && !done_nxt_i;
      if (!oe_i || active_i) tail_q <= '0;
      else if (run_q)        tail_q <= TailLd;   // chip enable just rose mid-stream
      else if (tail_q != '0) tail_q <= tail_q - 1'b1;
    end
  end

  assign run_o    = run_q;
  assign clk_en_o = oe_i && (run_q || tail_q != '0);

  AST_OE_KILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |=> (!run_q && tail_q == '0)); // R8
  AST_TAIL_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_q <= TailLd); // R7
  AST_TAIL_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tail_q != '0) |-> $past(run_q)); // R7
endmodule

// File: rtl/cfg_streamer.sv
module cfg_streamer
  import cfg_streamer_pkg::*;
#(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned LAST_ADDR = 1048575,
  parameter int unsigned TAIL_CYC  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_rst_ni,
  input  logic              busy_i,
  input  logic              par_mode_i,
  output logic [BYTE_W-1:0] dout_o,
  output logic              dout_en_o,
  output logic              clkout_o,
  output logic              clkout_en_o,
  output logic              ceo_o
);
  localparam logic [BIT_W-1:0] MsbIdx = BIT_W'(BYTE_W - 1);

  logic              active, run, step;
  logic [ADDR_W-1:0] addr_q, addr_nxt;
  logic [BIT_W-1:0]  bit_q;
  logic              done_q, done_nxt;
  logic [BYTE_W-1:0] mem_q;
  logic              ser_bit;

  assign active = !ce_ni && oe_rst_ni;
  // first enabled edge only starts CLKOUT; data advances from the next one
  assign step   = active && run && !busy_i;

  cfg_addr_ctr #(.ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR)) ctr_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (!active),
    .step_i     (step),
    .par_i      (par_mode_i),
    .addr_o     (addr_q),
    .addr_nxt_o (addr_nxt),
    .bit_o      (bit_q),
    .done_o     (done_q),
    .done_nxt_o (done_nxt)
  );

  cfg_mem #(.ADDR_W(ADDR_W)) mem_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_addr_i (addr_nxt),
    .rd_data_o (mem_q)
  );

  cfg_clk_ctl #(.TAIL_CYC(TAIL_CYC)) clk_i_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (active),
    .oe_i       (oe_rst_ni),
    .done_nxt_i (done_nxt),
    .run_o      (run),
    .clk_en_o   (clkout_en_o)
  );

  assign ser_bit   = mem_q[MsbIdx - bit_q];
  assign dout_en_o = active && !done_q;
  assign ceo_o     = !(active && done_q);
  assign clkout_o  = clk_i & clkout_en_o;

  always_comb begin
    if (!dout_en_o)     dout_o = '0;
    else if (par_mode_i) dout_o = mem_q;
    else                 dout_o = {{(BYTE_W-1){1'b0}}, ser_bit};
  end

  AST_MEM_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_q == cfg_byte(32'(addr_q))); // R3
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && active) |=> ($stable(addr_q) && $stable(bit_q))); // R5
endmodule

// File: tb/cfg_streamer_tb.sv
module cfg_streamer_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ce_ni = 1'b1, oe_rst_ni = 1'b1, busy_i = 1'b0, par_mode_i = 1'b1;
  logic [7:0] dout_o;
  logic       dout_en_o, clkout_o, clkout_en_o, ceo_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk_i = ~clk_i;

  cfg_streamer #(.ADDR_W(4), .LAST_ADDR(5), .TAIL_CYC(8)) dut_i (
    .clk_i, .rst_ni, .ce_ni, .oe_rst_ni, .busy_i, .par_mode_i,
    .dout_o, .dout_en_o, .clkout_o, .clkout_en_o, .ceo_o
  );

  function automatic logic [7:0] img(input int a);
    return 8'((a * 29 + 75) % 256);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic ce, input logic oe, input logic bsy, input logic par);
    @(negedge clk_i);
    ce_ni = ce; oe_rst_ni = oe; busy_i = bsy; par_mode_i = par;
  endtask

  task automatic edge_sample();
    @(posedge clk_i); #2;
  endtask

  // {ce_n, oe, busy, par, exp_en, exp_clk, exp_ceo, exp_dout[7:0]}
  localparam int NROW = 11;
  localparam logic [14:0] TBL [NROW] = '{
    {4'b1101, 3'b001, 8'h00},
    {4'b0101, 3'b111, 8'h4B},
    {4'b0101, 3'b111, 8'h68},
    {4'b0111, 3'b111, 8'h68},
    {4'b0101, 3'b111, 8'h85},
    {4'b0101, 3'b111, 8'hA2},
    {4'b0101, 3'b111, 8'hBF},
    {4'b0101, 3'b111, 8'hDC},
    {4'b0101, 3'b000, 8'h00},
    {4'b0101, 3'b000, 8'h00},
    {4'b1101, 3'b001, 8'h00}
  };

  function automatic string row_tag(input int r);
    if (r == 3) return "R5";
    if (r == 8 || r == 9) return "R6";
    if (r == 10 || r == 0) return "R2";
    return "R3";
  endfunction

  initial begin
    #(200000 * 10);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int idx;
    int cnt;
    #20;
    chk(dout_en_o == 0 && clkout_en_o == 0 && ceo_o == 1, "R1", "reset outputs",
        {dout_en_o, clkout_en_o, ceo_o}, 3'b001);
    @(negedge clk_i); rst_ni = 1'b1;

    // R2: chip enable high masks everything, whatever oe
    drive(1, 0, 0, 1); #1;
    chk(dout_en_o == 0 && ceo_o == 1, "R2", "ce high oe low", {dout_en_o, ceo_o}, 2'b01);

    for (int r = 0; r < NROW; r++) begin
      drive(TBL[r][14], TBL[r][13], TBL[r][12], TBL[r][11]);
      edge_sample();
      chk(dout_en_o == TBL[r][10], row_tag(r), $sformatf("row %0d dout_en", r), dout_en_o, TBL[r][10]);
      chk(clkout_en_o == TBL[r][9] && clkout_o == TBL[r][9], row_tag(r),
          $sformatf("row %0d clkout", r), {clkout_en_o, clkout_o}, {2{TBL[r][9]}});
      chk(ceo_o == TBL[r][8], row_tag(r), $sformatf("row %0d ceo", r), ceo_o, TBL[r][8]);
      if (TBL[r][10])
        chk(dout_o == TBL[r][7:0], row_tag(r), $sformatf("row %0d data", r), dout_o, TBL[r][7:0]);
    end

    // R4 serial, MSB first, with a stall (R5)
    drive(0, 1, 0, 0); edge_sample();
    idx = 0;
    chk(dout_o == {7'b0, img(0)[7]}, "R4", "serial first bit", dout_o, img(0)[7]);
    for (int i = 1; i < 20; i++) begin
      drive(0, 1, (i == 10), 0); edge_sample();
      if (i != 10) idx++;
      chk(dout_o == {7'b0, img(idx / 8)[7 - (idx % 8)]}, (i == 10) ? "R5" : "R4",
          $sformatf("serial bit %0d", idx), dout_o, img(idx / 8)[7 - (idx % 8)]);
      if (i == 10) chk(clkout_o == 1, "R5", "clkout during busy", clkout_o, 1);
    end

    // R7 tail after chip enable rise mid-stream
    drive(1, 1, 0, 1); #1;
    chk(dout_en_o == 0 && clkout_en_o == 1, "R7", "ce rise: data off clk on",
        {dout_en_o, clkout_en_o}, 2'b01);
    cnt = 0;
    for (int i = 0; i < 12; i++) begin
      edge_sample();
      if (clkout_en_o && cnt == i) cnt++;
    end
    chk(cnt == 8, "R7", "tail length", cnt, 8);
    chk(clkout_en_o == 0, "R7", "clkout off after tail", clkout_en_o, 0);

    // R8 oe low kills tail at once
    drive(0, 1, 0, 1); edge_sample(); edge_sample();
    drive(1, 1, 0, 1); edge_sample();
    @(negedge clk_i); oe_rst_ni = 1'b0; #1;
    chk(clkout_en_o == 0, "R8", "oe low during tail", clkout_en_o, 0);

    // R8 oe low mid-stream, then R9 restart at byte 0
    drive(0, 1, 0, 1); edge_sample(); edge_sample(); edge_sample();
    @(negedge clk_i); oe_rst_ni = 1'b0; #1;
    chk(clkout_en_o == 0 && dout_en_o == 0, "R8", "oe low mid-stream",
        {clkout_en_o, dout_en_o}, 2'b00);
    edge_sample();
    chk(clkout_en_o == 0, "R8", "clkout stays off", clkout_en_o, 0);
    drive(0, 1, 0, 1); edge_sample();
    chk(dout_o == img(0) && ceo_o == 1, "R9", "restart byte 0", dout_o, img(0));
    drive(0, 1, 0, 1); edge_sample();
    chk(dout_o == img(1), "R9", "restart byte 1", dout_o, img(1));

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule